// File: doc/BRIEF.md
# Magic Byte Sequence Bootloader Entry Detector

This block watches a stream of byte writes to a single write-only trigger register. It raises a bootloader-active flag only when eight particular bytes arrive one after another in a fixed order. A separate exit strobe drops the flag and returns the logic to its passive, listening state. Bus address decoding and the loader that acts on the flag are handled elsewhere. The block receives a write strobe with its data byte and an exit strobe, and it drives the active flag.

A write that breaks the sequence sends the match position back to the start. If the breaking byte is the opening byte of the sequence, it is taken as the first byte of a new attempt. Once the flag is set, further trigger writes are ignored until the exit strobe arrives. The register reads as zero.

Top module: `bt_entry_detect`

## Requirements
- R1: A synchronous active-high reset drives `boot_active` low and clears the match position. After reset, the trailing seven bytes of the sequence alone do not set the flag.
- R2: While passive, each trigger write that equals the next expected byte moves the match position on by one. `boot_active` stays low until the eighth byte has been written.
- R3: The expected bytes are 0xDE, 0xAD, 0xBE, 0xEF, 0xCA, 0xFE, 0xBA, 0xBE, in that order. When the eighth of them is written, `boot_active` is high from the clock edge that samples that write.
- R4: While passive, a write that differs from the expected byte sends the match position back to the start. If that byte is 0xDE, it counts as the first byte of a new attempt, so seven further correct bytes complete the sequence.
- R5: A cycle with `exit_req` high clears `boot_active` and the match position at the next clock edge. A trigger write in that same cycle is ignored.
- R6: While `boot_active` is high and `exit_req` is low, trigger writes of any value leave the flag high. They also leave the match position at the start, so after an exit a complete new eight-byte sequence is needed.
- R7: A cycle with neither a trigger write nor an exit strobe leaves both the flag and the match position unchanged.
- R8: `trig_rdata` reads as zero at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_wr | input | 1 | Trigger register write strobe, one byte per cycle |
| trig_wdata | input | 8 | Byte written to the trigger register |
| exit_req | input | 1 | Strobe that leaves bootloader mode |
| trig_rdata | output | 8 | Read value of the trigger register, always zero |
| boot_active | output | 1 | Bootloader mode is active |

## Verification
The assertions assume that `trig_wr`, `trig_wdata` and `exit_req` are known (not X) in every cycle after reset, and that a write lasts exactly one cycle per byte. The bench drives every input on the falling edge, so each strobe is clean for a single rising edge, and it holds the data bus at a defined value even when no write is made. The sweep places each of the 256 byte values at each of the eight sequence positions. A bench model of the sequence predicts the flag after every cycle. The model covers restarts on 0xDE, and it also covers strobes that collide with an exit.

// File: rtl/bt_pkg.sv
package bt_pkg;

    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned MAGIC_LEN = 8;
    localparam logic [MAGIC_LEN*BYTE_W-1:0] MAGIC_SEQ = 64'hDEAD_BEEF_CAFE_BABE;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        logic  valid;
        byte_t data;
    } wr_evt_t;

    typedef enum logic [2:0] {
        STEP_HOLD     = 3'd0,
        STEP_ADVANCE  = 3'd1,
        STEP_COMPLETE = 3'd2,
        STEP_RESTART  = 3'd3,
        STEP_ABORT    = 3'd4,
        STEP_EXIT     = 3'd5
    } step_t;

    // Decide what one cycle of input does to the matcher.
    function automatic step_t classify(
        input logic    exit_req,
        input logic    active,
        input wr_evt_t wr,
        input byte_t   exp_byte,
        input byte_t   first_byte,
        input logic    at_last
    );
        step_t s;
        if (exit_req) begin
            s = STEP_EXIT;
        end else if (active || !wr.valid) begin
            s = STEP_HOLD;
        end else if (wr.data == exp_byte) begin
            s = at_last ? STEP_COMPLETE : STEP_ADVANCE;
        end else if (wr.data == first_byte) begin
            s = STEP_RESTART;
        end else begin
            s = STEP_ABORT;
        end
        return s;
    endfunction

endpackage

// File: rtl/bt_seq_rom.sv
module bt_seq_rom
    import bt_pkg::*;
#(
    parameter int unsigned SEQ_LEN = MAGIC_LEN,
    parameter logic [SEQ_LEN*BYTE_W-1:0] SEQ_VALUE = MAGIC_SEQ,
    localparam int unsigned IDX_W = $clog2(SEQ_LEN)
) (
    input  logic [IDX_W-1:0] pos,
    output byte_t            exp_byte,
    output byte_t            first_byte
);

    byte_t lut [SEQ_LEN];

    // Byte 0 of the sequence sits in the most significant byte lane.
    for (genvar g = 0; g < SEQ_LEN; g++) begin : g_lane
        assign lut[g] = SEQ_VALUE[(SEQ_LEN-1-g)*BYTE_W +: BYTE_W];
    end

    assign exp_byte   = lut[pos];
    assign first_byte = lut[0];

endmodule

// File: rtl/bt_match_tracker.sv
module bt_match_tracker
    import bt_pkg::*;
#(
    parameter int unsigned SEQ_LEN = MAGIC_LEN,
    localparam int unsigned IDX_W = $clog2(SEQ_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  wr_evt_t          wr,
    input  logic             exit_req,
    input  logic             active,
    input  byte_t            exp_byte,
    input  byte_t            first_byte,
    output logic [IDX_W-1:0] pos,
    output step_t            step
);

    localparam logic [IDX_W-1:0] LAST_POS = IDX_W'(SEQ_LEN - 1);

    always_comb begin
        step = classify(exit_req, active, wr, exp_byte, first_byte,
                        pos == LAST_POS);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= '0;
        end else begin
            case (step)
                STEP_ADVANCE: pos <= pos + IDX_W'(1);
                STEP_RESTART: pos <= IDX_W'(1);
                STEP_COMPLETE,
                STEP_ABORT,
                STEP_EXIT:    pos <= '0;
                default:      pos <= pos;
            endcase
        end
    end

endmodule

// File: rtl/bt_mode_flag.sv
module bt_mode_flag
    import bt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  step_t step,
    output logic  active
);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
        end else if (step == STEP_EXIT) begin
            active <= 1'b0;
        end else if (step == STEP_COMPLETE) begin
            active <= 1'b1;
        end
    end

endmodule

// File: rtl/bt_entry_detect.sv
module bt_entry_detect
    import bt_pkg::*;
#(
    parameter int unsigned SEQ_LEN = MAGIC_LEN,
    parameter logic [SEQ_LEN*BYTE_W-1:0] SEQ_VALUE = MAGIC_SEQ,
    localparam int unsigned IDX_W = $clog2(SEQ_LEN)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trig_wr,
    input  logic [BYTE_W-1:0] trig_wdata,
    input  logic              exit_req,
    output logic [BYTE_W-1:0] trig_rdata,
    output logic              boot_active
);

    wr_evt_t          wr_evt;
    byte_t            exp_byte;
    byte_t            first_byte;
    logic [IDX_W-1:0] match_pos;
    step_t            step;

    assign wr_evt.valid = trig_wr;
    assign wr_evt.data  = trig_wdata;

    // The trigger register is write-only.
    assign trig_rdata = '0;

    bt_seq_rom #(
        .SEQ_LEN   (SEQ_LEN),
        .SEQ_VALUE (SEQ_VALUE)
    ) rom_i (
        .pos        (match_pos),
        .exp_byte   (exp_byte),
        .first_byte (first_byte)
    );

    bt_match_tracker #(
        .SEQ_LEN (SEQ_LEN)
    ) trk_i (
        .clk        (clk),
        .rst        (rst),
        .wr         (wr_evt),
        .exit_req   (exit_req),
        .active     (boot_active),
        .exp_byte   (exp_byte),
        .first_byte (first_byte),
        .pos        (match_pos),
        .step       (step)
    );

    bt_mode_flag flag_i (
        .clk    (clk),
        .rst    (rst),
        .step   (step),
        .active (boot_active)
    );

endmodule

// File: rtl/bt_entry_chk.sv
module bt_entry_chk
    import bt_pkg::*;
#(
    parameter int unsigned SEQ_LEN = MAGIC_LEN,
    parameter logic [SEQ_LEN*BYTE_W-1:0] SEQ_VALUE = MAGIC_SEQ,
    localparam int unsigned IDX_W = $clog2(SEQ_LEN)
) (
    input logic              clk,
    input logic              rst,
    input logic              trig_wr,
    input logic [BYTE_W-1:0] trig_wdata,
    input logic              exit_req,
    input logic              boot_active,
    input logic [IDX_W-1:0]  pos
);

    localparam logic [IDX_W-1:0] LAST_POS = IDX_W'(SEQ_LEN - 1);
    localparam byte_t OPEN_BYTE = SEQ_VALUE[(SEQ_LEN-1)*BYTE_W +: BYTE_W];

    byte_t want;
    always_comb begin
        want = '0;
        for (int i = 0; i < SEQ_LEN; i++) begin
            if (pos == IDX_W'(i)) want = SEQ_VALUE[(SEQ_LEN-1-i)*BYTE_W +: BYTE_W];
        end
    end

    logic live_wr;
    assign live_wr = trig_wr && !exit_req && !boot_active;

    // R1
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!boot_active && pos == '0));

    a_r2_advance: assert property (@(posedge clk) disable iff (rst)
        (live_wr && trig_wdata == want && pos != LAST_POS)
        |=> (pos == $past(pos) + IDX_W'(1) && !boot_active));

    a_r3_complete: assert property (@(posedge clk) disable iff (rst)
        (live_wr && trig_wdata == want && pos == LAST_POS)
        |=> (boot_active && pos == '0));

    a_r3_rise_needs_write: assert property (@(posedge clk) disable iff (rst)
        $rose(boot_active) |-> ($past(trig_wr) && !$past(exit_req)));

    a_r4_abort: assert property (@(posedge clk) disable iff (rst)
        (live_wr && trig_wdata != want && trig_wdata != OPEN_BYTE)
        |=> (pos == '0 && !boot_active));

    a_r4_restart: assert property (@(posedge clk) disable iff (rst)
        (live_wr && trig_wdata != want && trig_wdata == OPEN_BYTE)
        |=> (pos == IDX_W'(1)));

    a_r5_exit: assert property (@(posedge clk) disable iff (rst)
        exit_req |=> (!boot_active && pos == '0));

    a_r6_hold_active: assert property (@(posedge clk) disable iff (rst)
        (boot_active && !exit_req) |=> (boot_active && pos == '0));

    a_r7_idle: assert property (@(posedge clk) disable iff (rst)
        (!trig_wr && !exit_req) |=> ($stable(boot_active) && $stable(pos)));

endmodule

bind bt_entry_detect bt_entry_chk #(
    .SEQ_LEN   (SEQ_LEN),
    .SEQ_VALUE (SEQ_VALUE)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .trig_wr     (trig_wr),
    .trig_wdata  (trig_wdata),
    .exit_req    (exit_req),
    .boot_active (boot_active),
    .pos         (match_pos)
);

// File: tb/bt_entry_detect_tb.sv
module bt_entry_detect_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       trig_wr = 1'b0;
    logic [7:0] trig_wdata = 8'h00;
    logic       exit_req = 1'b0;
    logic [7:0] trig_rdata;
    logic       boot_active;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    // Bench model state
    logic       m_act = 1'b0;
    int         m_pos = 0;
    logic [7:0] seq [8] = '{8'hDE, 8'hAD, 8'hBE, 8'hEF, 8'hCA, 8'hFE, 8'hBA, 8'hBE};

    always #4 clk = ~clk;

    bt_entry_detect dut_i (
        .clk         (clk),
        .rst         (rst),
        .trig_wr     (trig_wr),
        .trig_wdata  (trig_wdata),
        .exit_req    (exit_req),
        .trig_rdata  (trig_rdata),
        .boot_active (boot_active)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model(input logic we, input logic [7:0] d, input logic ex);
        if (ex) begin
            m_act = 1'b0;
            m_pos = 0;
        end else if (we && !m_act) begin
            if (d == seq[m_pos]) begin
                if (m_pos == 7) begin
                    m_act = 1'b1;
                    m_pos = 0;
                end else begin
                    m_pos++;
                end
            end else if (d == 8'hDE) begin
                m_pos = 1;
            end else begin
                m_pos = 0;
            end
        end
    endtask

    // One clock cycle of stimulus, followed by a comparison after the edge.
    task automatic cyc(input logic we, input logic [7:0] d, input logic ex, input string req);
        @(negedge clk);
        trig_wr    = we;
        trig_wdata = d;
        exit_req   = ex;
        model(we, d, ex);
        @(posedge clk);
        #2;
        check(req, {7'd0, boot_active}, {7'd0, m_act});
        check("R8 rdata zero", trig_rdata, 8'h00);
        @(negedge clk);
        trig_wr  = 1'b0;
        exit_req = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check("R1 reset flag", {7'd0, boot_active}, 8'h00);
        check("R8 rdata at reset", trig_rdata, 8'h00);
        @(negedge clk);
        rst = 1'b0;

        // R1: a fresh reset leaves the position at the start
        for (int i = 1; i < 8; i++) cyc(1'b1, seq[i], 1'b0, "R1 tail after reset");
        check("R1 tail alone inactive", {7'd0, boot_active}, 8'h00);

        // R2, R3: the full sequence
        for (int i = 0; i < 8; i++) cyc(1'b1, seq[i], 1'b0, "R2 R3 in-order");
        check("R3 active after eighth", {7'd0, boot_active}, 8'h01);

        // R7: idle cycles leave the state alone
        for (int i = 0; i < 5; i++) cyc(1'b0, 8'h55, 1'b0, "R7 idle while active");

        // R6: every byte value is ignored while active
        for (int v = 0; v < 256; v++) cyc(1'b1, 8'(v), 1'b0, "R6 write while active");
        check("R6 still active", {7'd0, boot_active}, 8'h01);

        // R5: exit together with a write; then the tail alone must not reactivate
        cyc(1'b1, 8'hDE, 1'b1, "R5 exit with write");
        check("R5 exit clears", {7'd0, boot_active}, 8'h00);
        for (int i = 1; i < 8; i++) cyc(1'b1, seq[i], 1'b0, "R6 fresh sequence needed");
        check("R6 tail after exit inactive", {7'd0, boot_active}, 8'h00);

        // R5: exit partway through clears the position
        for (int i = 0; i < 4; i++) cyc(1'b1, seq[i], 1'b0, "R2 partial");
        cyc(1'b0, 8'h00, 1'b1, "R5 exit mid-sequence");
        for (int i = 4; i < 8; i++) cyc(1'b1, seq[i], 1'b0, "R5 remainder after exit");
        check("R5 partial cleared", {7'd0, boot_active}, 8'h00);

        // R7: idle gaps inside a sequence
        for (int i = 0; i < 8; i++) begin
            cyc(1'b1, seq[i], 1'b0, "R7 gapped sequence");
            cyc(1'b0, 8'hFF, 1'b0, "R7 gap");
        end
        check("R7 gapped sequence completes", {7'd0, boot_active}, 8'h01);

        // R4: sweep every value at every position, then feed the tail bytes
        for (int k = 0; k < 8; k++) begin
            for (int v = 0; v < 256; v++) begin
                cyc(1'b0, 8'h00, 1'b1, "R5 sweep exit");
                for (int i = 0; i < k; i++) cyc(1'b1, seq[i], 1'b0, "R2 sweep prefix");
                cyc(1'b1, 8'(v), 1'b0, "R4 sweep probe");
                for (int i = 1; i < 8; i++) cyc(1'b1, seq[i], 1'b0, "R4 sweep tail");
            end
        end

        // R4: a 0xDE restart directly after a near-complete prefix
        cyc(1'b0, 8'h00, 1'b1, "R5 exit");
        for (int i = 0; i < 7; i++) cyc(1'b1, seq[i], 1'b0, "R2 seven bytes");
        cyc(1'b1, 8'hDE, 1'b0, "R4 restart byte");
        check("R4 restart not active", {7'd0, boot_active}, 8'h00);
        for (int i = 1; i < 8; i++) cyc(1'b1, seq[i], 1'b0, "R4 restart tail");
        check("R4 restart completes", {7'd0, boot_active}, 8'h01);

        // R1: reset while active
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #2;
        check("R1 reset while active", {7'd0, boot_active}, 8'h00);
        @(negedge clk);
        rst = 1'b0;
        m_act = 1'b0;
        m_pos = 0;

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule